// File: doc/BRIEF.md
# Performance Counter Snapshot Unit

This block counts single-cycle event pulses in a free-running counter and, on request, moves the accumulated total into a holding register that software can read at leisure. A snapshot starts when the update request input goes from low to high. The unit then drops its status output, copies the running total into the holding register, and restarts the running count from the next interval. It also drives the zero-count flag low for one cycle as a visible marker of the load, and then raises the status output again.

The running counter never misses an event. An event that arrives in the cycle when the counter restarts is counted as the first event of the new interval. The counter saturates at its all-ones value and does not wrap. The zero-count flag reports whether the captured value is zero. The interface has only plain control and status pins: the request is a level handshake, and the holding register is a static register output. No data stream is carried, so there is no valid/ready pair and no back-pressure.

Top module: `perf_snap_counter`

## Requirements
- R1: While reset is asserted and immediately after it, the holding register reads 0, the status output is 1 and the zero flag is 1. Reset also clears the running count, so the first snapshot after reset returns 0 when no events arrived.
- R2: Each clock edge that samples the event input high adds one to the running count. The total appears in the holding register after the next snapshot.
- R3: A snapshot starts only at a clock edge that samples the request input high when it was low at the previous edge. Holding the request high starts no further snapshot, and the status output stays 1.
- R4: When a snapshot starts, the status output goes low in the cycle after the edge that saw the rising request. It stays low for exactly three cycles and then returns to 1.
- R5: The holding register receives the count of all events sampled up to and including the edge that saw the rising request. The new value is visible in the second cycle of the snapshot. The holding register does not change while the status output is 1.
- R6: The edge that loads the holding register also restarts the running count. If that edge samples an event, the new interval starts at 1 instead of 0, so no event is lost.
- R7: In the second cycle of every snapshot the zero flag is forced to 0, whatever the holding register holds. This lasts exactly one cycle.
- R8: Outside that forced cycle, the zero flag is 1 exactly when the holding register is 0.
- R9: The running count saturates at 2^CNT_W-1 and does not wrap, so the snapshot reports the saturated value.
- R10: A rising edge on the request input while a snapshot is in progress is ignored. If the request is still high when the snapshot ends, no new snapshot follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| event_i | input | 1 | Event pulse; one count per cycle sampled high |
| upd_req_i | input | 1 | Snapshot request; its rising edge starts an update |
| hold_o | output | CNT_W | Holding register with the last captured count |
| status_o | output | 1 | 1 when the holding register is valid and no update is running |
| zero_o | output | 1 | Zero-count flag of the holding register |

## Verification
The bench builds the unit with CNT_W set to 4, so the running count tops out at 15. A burst of twenty events then drives the counter into saturation within a few cycles, and the bench can show that the snapshot reports 15 and not a wrapped value. This width needs no change to the counting, edge detection or snapshot sequencing. The bench can therefore step through the three-cycle status gap, the single forced-low zero cycle, an event in the restart cycle, a held request and a re-raised request, all at that width.

// File: rtl/perf_snap_pkg.sv
package perf_snap_pkg;

  typedef enum logic [1:0] {
    SNAP_IDLE    = 2'd0,
    SNAP_CAPTURE = 2'd1,
    SNAP_ZMARK   = 2'd2,
    SNAP_DONE    = 2'd3
  } snap_state_e;

endpackage

// File: rtl/psu_edge_detect.sv
module psu_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic rise_o
);

  logic level_q;

  always_ff @(posedge clk) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level_i;
  end

  // rising edge: high now, low at the previous sampling edge
  assign rise_o = level_i & ~level_q;

endmodule

// File: rtl/psu_run_counter.sv
module psu_run_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         evt_i,
  input  logic         restart_i,
  output logic [W-1:0] count_o
);

  localparam logic [W-1:0] CNT_MAX = '1;
  localparam logic [W-1:0] CNT_ONE = W'(1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart_i) begin
      // an event in the restart cycle opens the new interval
      cnt_q <= evt_i ? CNT_ONE : '0;
    end else if (evt_i && (cnt_q != CNT_MAX)) begin
      cnt_q <= cnt_q + CNT_ONE;
    end
  end

  assign count_o = cnt_q;

endmodule

// File: rtl/psu_seq.sv
module psu_seq
  import perf_snap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic capture_o,
  output logic zmask_o,
  output logic busy_o
);

  snap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SNAP_IDLE:    if (start_i) state_d = SNAP_CAPTURE;
      SNAP_CAPTURE: state_d = SNAP_ZMARK;
      SNAP_ZMARK:   state_d = SNAP_DONE;
      SNAP_DONE:    state_d = SNAP_IDLE;
      default:      state_d = SNAP_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= SNAP_IDLE;
    else        state_q <= state_d;
  end

  assign capture_o = (state_q == SNAP_CAPTURE);
  assign zmask_o   = (state_q == SNAP_ZMARK);
  assign busy_o    = (state_q != SNAP_IDLE);

endmodule

// File: rtl/perf_snap_counter.sv
module perf_snap_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             event_i,
  input  logic             upd_req_i,
  output logic [CNT_W-1:0] hold_o,
  output logic             status_o,
  output logic             zero_o
);

  logic             req_rise;
  logic             capture;
  logic             zmask;
  logic             busy;
  logic [CNT_W-1:0] run_count;
  logic [CNT_W-1:0] hold_q;

  psu_edge_detect u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (upd_req_i),
    .rise_o  (req_rise)
  );

  psu_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (req_rise),
    .capture_o (capture),
    .zmask_o   (zmask),
    .busy_o    (busy)
  );

  psu_run_counter #(.W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (event_i),
    .restart_i (capture),
    .count_o   (run_count)
  );

  // holding register: loaded in the same edge that restarts the count
  always_ff @(posedge clk) begin
    if (!rst_n)       hold_q <= '0;
    else if (capture) hold_q <= run_count;
  end

  assign hold_o   = hold_q;
  assign status_o = ~busy;
  assign zero_o   = ~zmask & (hold_q == '0);

endmodule

// File: rtl/perf_snap_checker.sv
module perf_snap_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             upd_req_i,
  input logic [CNT_W-1:0] hold_o,
  input logic             status_o,
  input logic             zero_o
);

  assert_start_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_o) |-> ($past(upd_req_i) && !$past(upd_req_i, 2)));

  assert_status_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_o) |=> !status_o ##1 !status_o ##1 status_o);

  assert_hold_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o && $past(status_o)) |-> $stable(hold_o));

  assert_zero_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_o) |=> !zero_o ##1 (zero_o == (hold_o == '0)));

  assert_zero_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    status_o |-> (zero_o == (hold_o == '0)));

endmodule

bind perf_snap_counter perf_snap_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .upd_req_i (upd_req_i),
  .hold_o    (hold_o),
  .status_o  (status_o),
  .zero_o    (zero_o)
);

// File: tb/test_perf_snap_counter.sv
module test_perf_snap_counter;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 4;
  localparam int SAT        = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             event_i = 1'b0;
  logic             upd_req_i = 1'b0;
  logic [CNT_W-1:0] hold_o;
  logic             status_o;
  logic             zero_o;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  perf_snap_counter #(.CNT_W(CNT_W)) i_perf_snap_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .event_i   (event_i),
    .upd_req_i (upd_req_i),
    .hold_o    (hold_o),
    .status_o  (status_o),
    .zero_o    (zero_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_events(input int n);
    for (int i = 0; i < n; i++) begin
      event_i = 1'b1;
      step();
    end
    event_i = 1'b0;
  endtask

  // full snapshot; evc drives an event in the restart cycle
  task automatic snapshot(input int exp, input bit evc, input bit keep_high);
    upd_req_i = 1'b0;
    step();
    upd_req_i = 1'b1;
    step();                                   // edge sees rising request
    check("R4 status low cycle1", status_o, 0);
    event_i = evc;
    step();                                   // load + restart edge
    event_i = 1'b0;
    check("R4 status low cycle2", status_o, 0);
    check("R7 zero forced low", zero_o, 0);
    check("R5/R2 captured count", hold_o, exp);
    step();
    check("R4 status low cycle3", status_o, 0);
    check("R8 zero after pulse", zero_o, (exp == 0) ? 1 : 0);
    step();
    check("R4 status back high", status_o, 1);
    if (!keep_high) upd_req_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 hold at reset", hold_o, 0);
    check("R1 status at reset", status_o, 1);
    check("R1 zero at reset", zero_o, 1);
    snapshot(0, 1'b0, 1'b0);
  endtask

  task automatic t_count_basic();
    pulse_events(5);
    snapshot(5, 1'b0, 1'b0);
    snapshot(0, 1'b0, 1'b0);
  endtask

  task automatic t_count_gaps();
    for (int i = 0; i < 3; i++) begin
      pulse_events(1);
      step();
      step();
    end
    snapshot(3, 1'b0, 1'b0);
  endtask

  task automatic t_no_loss();
    pulse_events(2);
    snapshot(2, 1'b1, 1'b0);                  // R6: event in restart cycle
    snapshot(1, 1'b0, 1'b0);
  endtask

  task automatic t_level_held();
    pulse_events(1);
    snapshot(1, 1'b0, 1'b1);
    for (int i = 0; i < 6; i++) begin
      event_i = (i < 2);
      step();
      check("R3 held request no update", status_o, 1);
      check("R3 hold unchanged", hold_o, 1);
    end
    event_i = 1'b0;
    snapshot(2, 1'b0, 1'b0);
  endtask

  task automatic t_retrigger();
    pulse_events(4);
    upd_req_i = 1'b0;
    step();
    upd_req_i = 1'b1;
    step();                                   // update starts
    upd_req_i = 1'b0;
    step();                                   // load edge
    check("R10 capture", hold_o, 4);
    upd_req_i = 1'b1;                         // rise during update
    step();
    step();
    check("R10 status back", status_o, 1);
    for (int i = 0; i < 4; i++) begin
      step();
      check("R10 no second update", status_o, 1);
      check("R10 zero flag steady", zero_o, 0);
    end
    upd_req_i = 1'b0;
    snapshot(0, 1'b0, 1'b0);
  endtask

  task automatic t_saturate();
    pulse_events(20);
    snapshot(SAT, 1'b0, 1'b0);                // R9
    snapshot(0, 1'b0, 1'b0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin : main
    @(negedge clk);
    step();
    check("R1 status during reset", status_o, 1);
    check("R1 zero during reset", zero_o, 1);
    rst_n = 1'b1;
    step();
    t_reset();
    t_count_basic();
    t_count_gaps();
    t_no_loss();
    t_level_held();
    t_retrigger();
    t_saturate();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule